// File: doc/BRIEF.md
# Byte-Readable Wide-Sample Capture RAM

This block is a two-port storage array for captured samples. One side, the sample port, writes a whole sample of 8, 16 or 32 bits per clock at a word address. The other side, the control port, reads the stored samples back one byte at a time, so a narrow control path can drain a wide capture buffer.

The control-port address is the word address with the byte-lane bits appended below it. Read data leaves through a register clocked by the control clock.

A parameter picks the clocking. In single-clock mode the control clock runs both ports and the sample-clock pin is ignored. In two-clock mode each port runs on its own clock.

Neither port has back-pressure. A write is accepted on every write-clock edge where the write enable is high. A new read address may be presented on every control-clock cycle, and each one yields its byte one cycle later.

Top module: `capture_ram`

## Requirements
- R1: `SAMPLE_W` may be 8, 16 or 32. The read address is `WADDR_W + log2(SAMPLE_W/8)` bits wide. Its upper `WADDR_W` bits select the stored word and its lower bits select the byte lane.
- R2: Byte lanes are little-endian. Lane value k returns bits `8k+7:8k` of the stored sample, so lane 0 is bits 7:0.
- R3: The read byte is registered on `ctl_clk`. It shows the byte addressed before a rising `ctl_clk` edge from just after that edge, and it holds until the next edge.
- R4: A write stores `smp_data` at `smp_addr` on a rising write-clock edge when `smp_we` is 1. When `smp_we` is 0, the stored word keeps its value.
- R5: With `DUAL_CLK = 0`, writes are taken on `ctl_clk` only. Edges on `smp_clk` have no effect on the stored contents.
- R6: With `DUAL_CLK = 1`, writes are taken on `smp_clk` and reads on `ctl_clk`. A written sample reads back correctly once two control-clock edges have passed after the write.
- R7: `arst` high forces `rd_byte` to 0 at once, without waiting for a clock edge. Memory contents survive the reset.
- R8: With `DUAL_CLK = 0`, reading a word on the same edge that writes it returns the old contents. The new contents appear on the following read.
- R9: The read port takes a different address on every consecutive `ctl_clk` cycle, with no idle cycles, and returns the matching byte for each one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ctl_clk | input | 1 | Control clock. Clocks the read side, and both sides in single-clock mode. |
| smp_clk | input | 1 | Sample clock for the write side. Ignored when `DUAL_CLK = 0`. |
| arst | input | 1 | Asynchronous reset, active high. Clears the read-data register only. |
| smp_we | input | 1 | Write enable for the sample port. |
| smp_addr | input | WADDR_W | Word address for a write. |
| smp_data | input | SAMPLE_W | Sample to be written. |
| rd_addr | input | WADDR_W+log2(SAMPLE_W/8) | Byte address for a read: word in the upper bits, lane in the lower bits. |
| rd_byte | output | 8 | Registered read byte. |

## Verification
The bench builds three instances:
- a 16-bit, 32-word instance in single-clock mode;
- a 32-bit, 16-word instance in two-clock mode, with an unrelated sample clock;
- an 8-bit, 16-word instance in single-clock mode with no lane bits.

Together these cover all three sample widths, the two-bit, one-bit and zero-bit lane fields, and both clock modes. The single-clock instances also reach the same-edge read/write collision and the ignored sample clock. The two-clock instance covers the clock crossing through the array.

// File: rtl/capture_ram_pkg.sv
package capture_ram_pkg;

  typedef logic [7:0] byte_t;

  // Number of byte-lane select bits for a given sample width.
  function automatic int lane_bits(input int sample_w);
    return (sample_w == 32) ? 2 : (sample_w == 16) ? 1 : 0;
  endfunction

endpackage

// File: rtl/capture_ram_store.sv
module capture_ram_store #(
  parameter int SAMPLE_W = 16,
  parameter int WADDR_W  = 6,
  parameter int DUAL_CLK = 0,
  localparam int DEPTH   = 1 << WADDR_W
) (
  input  logic                ctl_clk,
  input  logic                smp_clk,
  input  logic                arst,
  input  logic                we,
  input  logic [WADDR_W-1:0]  waddr,
  input  logic [SAMPLE_W-1:0] wdata,
  input  logic [WADDR_W-1:0]  raddr,
  output logic [SAMPLE_W-1:0] rword
);

  logic                wclk;
  logic [SAMPLE_W-1:0] mem [DEPTH];

  // The clock mode selects which clock drives the write port.
  generate
    if (DUAL_CLK != 0) begin : g_two_clk
      assign wclk = smp_clk;
    end else begin : g_one_clk
      assign wclk = ctl_clk;
    end
  endgenerate

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Unregistered array read; the top registers the selected byte.
  assign rword = mem[raddr];

  AST_WRITE_LANDS: assert property (@(posedge wclk) disable iff (arst)
    we |=> (mem[$past(waddr)] == $past(wdata))); // R4

endmodule

// File: rtl/capture_ram_lane_pick.sv
module capture_ram_lane_pick
  import capture_ram_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int LANE_IW  = 1,
  localparam int LANES   = SAMPLE_W / 8,
  localparam int SLOTS   = 1 << LANE_IW
) (
  input  logic [SAMPLE_W-1:0] word_i,
  input  logic [LANE_IW-1:0]  lane_i,
  output byte_t               byte_o
);

  byte_t slot [SLOTS];

  // Slot k carries bits 8k+7:8k of the sample (little-endian lanes).
  // Slots beyond the lane count wrap back onto the real lanes.
  generate
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      assign slot[k] = word_i[8*(k % LANES) +: 8];
    end
  endgenerate

  assign byte_o = slot[lane_i];

endmodule

// File: rtl/capture_ram.sv
module capture_ram
  import capture_ram_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int WADDR_W  = 6,
  parameter int DUAL_CLK = 0,
  localparam int LANE_W  = lane_bits(SAMPLE_W),
  localparam int RADDR_W = WADDR_W + LANE_W
) (
  input  logic                ctl_clk,
  input  logic                smp_clk,
  input  logic                arst,
  input  logic                smp_we,
  input  logic [WADDR_W-1:0]  smp_addr,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [RADDR_W-1:0]  rd_addr,
  output logic [7:0]          rd_byte
);

  localparam int LANE_IW = (LANE_W > 0) ? LANE_W : 1;

  generate
    if (!(SAMPLE_W == 8 || SAMPLE_W == 16 || SAMPLE_W == 32)) begin : g_bad_width
      $error("capture_ram: SAMPLE_W must be 8, 16 or 32");
    end
    if (WADDR_W < 4 || WADDR_W > 16) begin : g_bad_depth
      $error("capture_ram: WADDR_W must lie in 4..16");
    end
  endgenerate

  logic [WADDR_W-1:0]  rd_word;
  logic [LANE_IW-1:0]  rd_lane;
  logic [SAMPLE_W-1:0] rd_sample;
  byte_t               rd_pick;
  byte_t               rd_q;

  // R1: word address in the upper bits, lane select in the lower bits.
  assign rd_word = rd_addr[RADDR_W-1 -: WADDR_W];

  generate
    if (LANE_W > 0) begin : g_lane
      assign rd_lane = rd_addr[LANE_IW-1:0];
    end else begin : g_nolane
      assign rd_lane = '0;
    end
  endgenerate

  capture_ram_store #(
    .SAMPLE_W (SAMPLE_W),
    .WADDR_W  (WADDR_W),
    .DUAL_CLK (DUAL_CLK)
  ) u_store (
    .ctl_clk (ctl_clk),
    .smp_clk (smp_clk),
    .arst    (arst),
    .we      (smp_we),
    .waddr   (smp_addr),
    .wdata   (smp_data),
    .raddr   (rd_word),
    .rword   (rd_sample)
  );

  capture_ram_lane_pick #(
    .SAMPLE_W (SAMPLE_W),
    .LANE_IW  (LANE_IW)
  ) u_pick (
    .word_i (rd_sample),
    .lane_i (rd_lane),
    .byte_o (rd_pick)
  );

  // Read-data register: the only state cleared by the asynchronous reset.
  always_ff @(posedge ctl_clk or posedge arst) begin
    if (arst) rd_q <= '0;
    else      rd_q <= rd_pick;
  end

  assign rd_byte = rd_q;

  AST_RST_CLEAR: assert property (@(posedge ctl_clk)
    arst |-> (rd_byte == 8'h00)); // R7

  // In single-clock mode the read path can be tracked against writes.
  generate
    if (DUAL_CLK == 0) begin : g_chk_one_clk
      logic                wr_d;
      logic                armed;
      logic [WADDR_W-1:0]  wa_d;
      logic [SAMPLE_W-1:0] wd_d;

      always_ff @(posedge ctl_clk or posedge arst) begin
        if (arst) begin
          wr_d  <= 1'b0;
          armed <= 1'b0;
          wa_d  <= '0;
          wd_d  <= '0;
        end else begin
          wr_d  <= smp_we;
          armed <= 1'b1;
          wa_d  <= smp_addr;
          wd_d  <= smp_data;
        end
      end

      AST_HOLD_IDLE: assert property (@(posedge ctl_clk) disable iff (arst)
        (armed && !wr_d && $stable(rd_addr)) |=> $stable(rd_byte)); // R3

      AST_RD_AFTER_WR: assert property (@(posedge ctl_clk) disable iff (arst)
        (wr_d && rd_word == wa_d) |=>
        (rd_byte == 8'($past(wd_d) >> (8 * $past(rd_lane))))); // R2
    end
  endgenerate

endmodule

// File: tb/capture_ram_tb.sv
module capture_ram_tb;

  logic clk   = 1'b0;
  logic wclk2 = 1'b0;
  logic arst  = 1'b0;
  logic done  = 1'b0;
  int   n_chk = 0;
  int   n_bad = 0;

  always #10 clk   = ~clk;   // 50 MHz control clock
  always #7  wclk2 = ~wclk2; // unrelated sample clock

  // Instance A: 16-bit samples, 32 words, single clock.
  logic        a_we = 0, a_sclk = 0;
  logic [4:0]  a_wa = 0;
  logic [15:0] a_wd = 0;
  logic [5:0]  a_ra = 0;
  logic [7:0]  a_rb;
  logic [15:0] a_sh [32];

  // Instance B: 32-bit samples, 16 words, two clocks.
  logic        b_we = 0;
  logic [3:0]  b_wa = 0;
  logic [31:0] b_wd = 0;
  logic [5:0]  b_ra = 0;
  logic [7:0]  b_rb;
  logic [31:0] b_sh [16];

  // Instance C: 8-bit samples, 16 words, single clock.
  logic        c_we = 0;
  logic [3:0]  c_wa = 0;
  logic [7:0]  c_wd = 0;
  logic [3:0]  c_ra = 0;
  logic [7:0]  c_rb;
  logic [7:0]  c_sh [16];

  capture_ram #(.SAMPLE_W(16), .WADDR_W(5), .DUAL_CLK(0)) u_dut (
    .ctl_clk(clk), .smp_clk(a_sclk), .arst(arst), .smp_we(a_we),
    .smp_addr(a_wa), .smp_data(a_wd), .rd_addr(a_ra), .rd_byte(a_rb));

  capture_ram #(.SAMPLE_W(32), .WADDR_W(4), .DUAL_CLK(1)) u_dut_dual (
    .ctl_clk(clk), .smp_clk(wclk2), .arst(arst), .smp_we(b_we),
    .smp_addr(b_wa), .smp_data(b_wd), .rd_addr(b_ra), .rd_byte(b_rb));

  capture_ram #(.SAMPLE_W(8), .WADDR_W(4), .DUAL_CLK(0)) u_dut_byte (
    .ctl_clk(clk), .smp_clk(wclk2), .arst(arst), .smp_we(c_we),
    .smp_addr(c_wa), .smp_data(c_wd), .rd_addr(c_ra), .rd_byte(c_rb));

  // Expected byte: lane k is bits 8k+7:8k (R2).
  function automatic logic [7:0] lane_of(input logic [31:0] w, input int k);
    return w[8*k +: 8];
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Writes: called at a negedge of clk, return at the next one.
  task automatic a_write(input logic [4:0] a, input logic [15:0] d);
    a_we = 1; a_wa = a; a_wd = d;
    @(negedge clk);
    a_we = 0;
    a_sh[a] = d;
  endtask

  task automatic c_write(input logic [3:0] a, input logic [7:0] d);
    c_we = 1; c_wa = a; c_wd = d;
    @(negedge clk);
    c_we = 0;
    c_sh[a] = d;
  endtask

  task automatic b_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge wclk2);
    b_we = 1; b_wa = a; b_wd = d;
    @(negedge wclk2);
    b_we = 0;
    b_sh[a] = d;
  endtask

  // Reads: address applied at a negedge, byte sampled one edge later (R3).
  task automatic a_read(input string req, input logic [5:0] ra);
    a_ra = ra;
    @(negedge clk);
    check(req, a_rb, lane_of({16'h0, a_sh[ra[5:1]]}, int'(ra[0])));
  endtask

  task automatic b_read(input string req, input logic [5:0] ra);
    b_ra = ra;
    @(negedge clk);
    check(req, b_rb, lane_of(b_sh[ra[5:2]], int'(ra[1:0])));
  endtask

  task automatic c_read(input string req, input logic [3:0] ra);
    c_ra = ra;
    @(negedge clk);
    check(req, c_rb, c_sh[ra]);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin : main
    logic [15:0] old16;
    void'($urandom(32'h5EED_0042));
    #1 arst = 1;
    repeat (3) @(negedge clk);
    check("R7 reset A", a_rb, 8'h00);
    check("R7 reset B", b_rb, 8'h00);
    check("R7 reset C", c_rb, 8'h00);
    arst = 0;
    @(negedge clk);

    // Fill every word with random data (R4, R6).
    for (int i = 0; i < 32; i++) a_write(5'(i), 16'($urandom));
    for (int i = 0; i < 16; i++) c_write(4'(i), 8'($urandom));
    for (int i = 0; i < 16; i++) b_write(4'(i), $urandom);
    @(negedge clk); @(negedge clk);

    // Directed lane patterns (R2, R1).
    a_write(5'd3, 16'hA55A);
    a_write(5'd31, 16'h1234);
    b_write(4'd5, 32'h4433_2211);
    b_write(4'd15, 32'hDEAD_BEEF);
    c_write(4'd15, 8'hC3);
    @(negedge clk); @(negedge clk);
    a_read("R2 lane0 A", 6'd6);
    check("R2 lane0 A const", a_rb, 8'h5A);
    a_read("R2 lane1 A", 6'd7);
    check("R2 lane1 A const", a_rb, 8'hA5);
    a_read("R1 top word A", 6'd63);
    check("R1 top word A const", a_rb, 8'h12);
    for (int k = 0; k < 4; k++) begin
      b_read("R2 lanes B", 6'(20 + k));
      check("R2 lanes B const", b_rb, 8'(8'h11 * (k + 1)));
    end
    b_read("R1 top word B", 6'd63);
    check("R1 top word B const", b_rb, 8'hDE);
    c_read("R1 no-lane C", 4'd15);
    check("R1 no-lane C const", c_rb, 8'hC3);

    // Back-to-back reads of every byte (R9, R6, R4).
    for (int i = 0; i < 64; i++) a_read("R9 sweep A", 6'(i));
    for (int i = 0; i < 64; i++) b_read("R6 sweep B", 6'(i));
    for (int i = 0; i < 16; i++) c_read("R9 sweep C", 4'(i));

    // Random reads interleaved with random writes (R4).
    for (int n = 0; n < 200; n++) begin
      if ($urandom_range(0, 2) == 0) a_write(5'($urandom), 16'($urandom));
      else a_read("R4 random A", 6'($urandom));
    end

    // Held address: output stays put across idle edges (R3).
    a_read("R3 hold A", 6'd10);
    repeat (3) begin
      @(negedge clk);
      check("R3 hold A", a_rb, lane_of({16'h0, a_sh[5]}, 0));
    end

    // Same-edge write and read of one word (R8).
    old16 = a_sh[9];
    a_ra = 6'd19; a_we = 1; a_wa = 5'd9; a_wd = ~old16;
    @(negedge clk);
    a_we = 0;
    check("R8 collision old", a_rb, old16[15:8]);
    a_sh[9] = ~old16;
    @(negedge clk);
    check("R8 collision new", a_rb, a_sh[9][15:8]);

    // Sample clock ignored in single-clock mode (R5).
    old16 = a_sh[12];
    a_we = 1; a_wa = 5'd12; a_wd = old16 ^ 16'hFFFF;
    #3 a_sclk = 1;
    #3 a_sclk = 0;
    #2 a_we = 0;
    @(negedge clk);
    a_read("R5 smp_clk ignored lo", 6'd24);
    a_read("R5 smp_clk ignored hi", 6'd25);

    // Asynchronous reset mid-cycle; memory survives (R7).
    a_read("R7 pre", 6'd7);
    b_read("R7 pre B", 6'd21);
    #4 arst = 1;
    #2;
    check("R7 async clear A", a_rb, 8'h00);
    check("R7 async clear B", b_rb, 8'h00);
    @(negedge clk);
    arst = 0;
    @(negedge clk);
    a_read("R7 memory kept A", 6'd7);
    b_read("R7 memory kept B", 6'd21);
    c_read("R7 memory kept C", 4'd15);

    done = 1;
    summary();
    $finish;
  end

endmodule